// File: doc/BRIEF.md
# Outstanding Request Table with Conflict Check

This block sits in each cache controller beside a split-transaction bus and mirrors every transaction that has been granted the request bus and has not yet seen its response. Each slot is selected by the bus tag that arbitration handed to the request. The slot keeps the block address, the request kind, this cache's snoop state for the block, and two flags. One flag marks that this controller issued the request. The other marks that this controller wants to capture the response data. A response carrying a tag releases that slot, and the freed tag can then be given out again.

Each slot is written by tag, but the table is searched by address, comparing against all slots at once. When the processor side asks whether it may put a request on the bus, the search decides among three outcomes. The request may be issued. It may be stalled behind an incompatible pending transaction. Or, for a read that matches a pending read, the controller joins that transaction and takes its data without going on the bus. The block also watches the request bus for a lost race. If another controller commits a conflicting request to the same block in the slot just before this controller's own request, the own request is dropped and reported as withdrawn.

All outputs are registered and appear one clock after the inputs that cause them.

Top module: `outstanding_req_table`

## Requirements
- R1: After synchronous reset, every output is 0 and every slot is empty, so the first lookup of any address returns issue (decision code 0).
- R2: A committed bus request of kind read (code 0) or read-for-ownership (code 1) is stored in the slot whose index equals its bus tag. From the next cycle on, a lookup of its address reports that tag.
- R3: A processor read that matches a pending read gets the join decision (code 2) with that slot's tag, and the slot's grab flag is set. When that slot's response arrives, the response report shows grab = 1 and the shared output is 1 for one cycle.
- R4: A processor lookup that matches a pending slot, where the processor request and the slot are not both reads, gets the stall decision (code 1) with that slot's tag. Stall takes priority over join when both kinds of match exist.
- R5: A response whose tag names a valid slot frees that slot. One cycle later the response report is valid and carries the slot's original-requester flag, which is set when the bus request arrived with the own flag. After the release, a lookup of that address returns issue.
- R6: A snoop state written to a valid slot is held in the slot and reported with that slot's response.
- R7: Upgrade (code 2) and write-back (code 3) requests are never stored, so a later lookup of their address returns issue.
- R8: An own request that follows, in the very next cycle, another controller's request to the same block, where the two are not both reads, is not stored. One cycle later the withdraw output pulses with the own tag. Two adjacent reads to one block cause no withdraw.
- R9: When the same cycle both writes a slot and performs a lookup, the lookup sees the new slot. When the same cycle both frees a slot and performs a lookup, the lookup no longer sees that slot.
- R10: A response whose tag names an empty slot produces no valid response report.
- R11: The decision output is valid exactly one cycle after each lookup request, and it never carries code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_valid | input | 1 | A request is committed on the bus this cycle |
| bus_req_own | input | 1 | The committed request was issued by this controller |
| bus_req_tag | input | TAG_W | Bus tag of the committed request |
| bus_req_addr | input | ADDR_W | Block address of the committed request |
| bus_req_kind | input | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_rsp_valid | input | 1 | A response is seen on the bus this cycle |
| bus_rsp_tag | input | TAG_W | Tag carried by the response |
| snp_valid | input | 1 | Write a local snoop state into a slot |
| snp_tag | input | TAG_W | Slot that receives the snoop state |
| snp_state | input | STATE_W | Local snoop state value |
| cpu_req_valid | input | 1 | Processor-side lookup request |
| cpu_req_addr | input | ADDR_W | Block address to look up |
| cpu_req_kind | input | 2 | Kind of the intended request, same codes as the bus |
| cpu_dec_valid | output | 1 | Decision valid |
| cpu_dec | output | 2 | 0 issue, 1 stall, 2 join |
| cpu_dec_tag | output | TAG_W | Matching slot for stall or join |
| rsp_out_valid | output | 1 | A valid slot was released |
| rsp_out_tag | output | TAG_W | Tag of the released slot |
| rsp_out_orig | output | 1 | Released slot was issued by this controller |
| rsp_out_grab | output | 1 | Released slot was marked to capture data |
| rsp_out_state | output | STATE_W | Stored snoop state of the released slot |
| shared_out | output | 1 | Drive the shared line for a captured response |
| withdraw_valid | output | 1 | Own request lost a slot race and was dropped |
| withdraw_tag | output | TAG_W | Tag of the dropped own request |

## Verification
A slot write, a slot release and a processor lookup can all fall on the same clock edge, and the lookup has to see the table as it stands after the write or release. The bench drives a bus request and a lookup of the same address in one cycle and expects a stall naming the new tag. It then drives that tag's response and a second lookup in one cycle and expects issue. The race detector is tested with an adjacent conflicting pair and with an adjacent pair of reads, which must not withdraw.

// File: rtl/ort_pkg.sv
package ort_pkg;
  typedef enum logic [1:0] {
    RQ_READ = 2'd0,
    RQ_RDX  = 2'd1,
    RQ_UPGR = 2'd2,
    RQ_WB   = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    DEC_ISSUE = 2'd0,
    DEC_STALL = 2'd1,
    DEC_JOIN  = 2'd2
  } cpu_dec_e;

  // Only requests that wait for a data response occupy a slot.
  function automatic logic kind_tracked(input logic [1:0] k);
    return (k == RQ_READ) || (k == RQ_RDX);
  endfunction

  // Two requests to one block coexist only if both are plain reads.
  function automatic logic kinds_conflict(input logic [1:0] a, input logic [1:0] b);
    return !((a == RQ_READ) && (b == RQ_READ));
  endfunction
endpackage

// File: rtl/ort_entry.sv
module ort_entry #(
  parameter int ADDR_W  = 26,
  parameter int STATE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_en,
  input  logic [ADDR_W-1:0]  alloc_addr,
  input  logic [1:0]         alloc_kind,
  input  logic               alloc_orig,
  input  logic               free_en,
  input  logic               snp_en,
  input  logic [STATE_W-1:0] snp_state,
  input  logic               grab_en,
  output logic               ent_valid,
  output logic [ADDR_W-1:0]  ent_addr,
  output logic [1:0]         ent_kind,
  output logic               ent_orig,
  output logic               ent_grab,
  output logic [STATE_W-1:0] ent_state
);
  // A write beats a release to the same slot: the tag has been reissued.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= 1'b0;
      ent_addr  <= '0;
      ent_kind  <= 2'd0;
      ent_orig  <= 1'b0;
      ent_grab  <= 1'b0;
      ent_state <= '0;
    end else if (alloc_en) begin
      ent_valid <= 1'b1;
      ent_addr  <= alloc_addr;
      ent_kind  <= alloc_kind;
      ent_orig  <= alloc_orig;
      ent_grab  <= grab_en;
      ent_state <= snp_en ? snp_state : '0;
    end else if (free_en) begin
      ent_valid <= 1'b0;
      ent_orig  <= 1'b0;
      ent_grab  <= 1'b0;
      ent_state <= '0;
    end else begin
      if (snp_en && ent_valid)  ent_state <= snp_state;
      if (grab_en && ent_valid) ent_grab  <= 1'b1;
    end
  end
endmodule

// File: rtl/ort_match.sv
module ort_match
  import ort_pkg::*;
#(
  parameter int N      = 8,
  parameter int ADDR_W = 26,
  parameter int TAG_W  = 3
) (
  input  logic [N-1:0]             vis_valid,
  input  logic [N-1:0][ADDR_W-1:0] vis_addr,
  input  logic [N-1:0][1:0]        vis_kind,
  input  logic [ADDR_W-1:0]        look_addr,
  input  logic [1:0]               look_kind,
  output logic [1:0]               dec,
  output logic [TAG_W-1:0]         dec_tag,
  output logic [N-1:0]             join_sel
);
  logic [N-1:0] hit;
  logic [N-1:0] blocks;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i]    = vis_valid[i] && (vis_addr[i] == look_addr);
    assign blocks[i] = hit[i] && kinds_conflict(vis_kind[i], look_kind);
  end

  logic [TAG_W-1:0] blk_idx, hit_idx;
  always_comb begin
    blk_idx = '0;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (blocks[i]) blk_idx = TAG_W'(i);
      if (hit[i])    hit_idx = TAG_W'(i);
    end
  end

  always_comb begin
    join_sel = '0;
    if (|blocks) begin
      dec     = DEC_STALL;
      dec_tag = blk_idx;
    end else if (|hit) begin
      dec     = DEC_JOIN;
      dec_tag = hit_idx;
      join_sel[hit_idx] = 1'b1;
    end else begin
      dec     = DEC_ISSUE;
      dec_tag = '0;
    end
  end
endmodule

// File: rtl/ort_race.sv
module ort_race
  import ort_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_own,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  output logic              kill
);
  logic              prev_valid;
  logic              prev_own;
  logic [ADDR_W-1:0] prev_addr;
  logic [1:0]        prev_kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= 1'b0;
      prev_own   <= 1'b0;
      prev_addr  <= '0;
      prev_kind  <= 2'd0;
    end else begin
      prev_valid <= req_valid;
      prev_own   <= req_own;
      prev_addr  <= req_addr;
      prev_kind  <= req_kind;
    end
  end

  assign kill = req_valid && req_own && prev_valid && !prev_own &&
                (prev_addr == req_addr) && kinds_conflict(prev_kind, req_kind);
endmodule

// File: rtl/outstanding_req_table.sv
module outstanding_req_table
  import ort_pkg::*;
#(
  parameter int NUM_TAGS = 8,
  parameter int ADDR_W   = 26,
  parameter int STATE_W  = 2,
  localparam int TAG_W   = $clog2(NUM_TAGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_req_valid,
  input  logic               bus_req_own,
  input  logic [TAG_W-1:0]   bus_req_tag,
  input  logic [ADDR_W-1:0]  bus_req_addr,
  input  logic [1:0]         bus_req_kind,
  input  logic               bus_rsp_valid,
  input  logic [TAG_W-1:0]   bus_rsp_tag,
  input  logic               snp_valid,
  input  logic [TAG_W-1:0]   snp_tag,
  input  logic [STATE_W-1:0] snp_state,
  input  logic               cpu_req_valid,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic [1:0]         cpu_req_kind,
  output logic               cpu_dec_valid,
  output logic [1:0]         cpu_dec,
  output logic [TAG_W-1:0]   cpu_dec_tag,
  output logic               rsp_out_valid,
  output logic [TAG_W-1:0]   rsp_out_tag,
  output logic               rsp_out_orig,
  output logic               rsp_out_grab,
  output logic [STATE_W-1:0] rsp_out_state,
  output logic               shared_out,
  output logic               withdraw_valid,
  output logic [TAG_W-1:0]   withdraw_tag
);
  logic [NUM_TAGS-1:0]              e_valid, e_orig, e_grab;
  logic [NUM_TAGS-1:0][ADDR_W-1:0]  e_addr;
  logic [NUM_TAGS-1:0][1:0]         e_kind;
  logic [NUM_TAGS-1:0][STATE_W-1:0] e_state;

  logic [NUM_TAGS-1:0]              alloc_hit, free_hit, snp_hit, grab_hit;
  logic [NUM_TAGS-1:0]              vis_valid;
  logic [NUM_TAGS-1:0][ADDR_W-1:0]  vis_addr;
  logic [NUM_TAGS-1:0][1:0]         vis_kind;

  logic             race_kill;
  logic             alloc_ok;
  logic [1:0]       look_dec;
  logic [TAG_W-1:0] look_tag;
  logic [NUM_TAGS-1:0] join_sel;

  ort_race #(.ADDR_W(ADDR_W)) u_race (
    .clk      (clk),
    .rst      (rst),
    .req_valid(bus_req_valid),
    .req_own  (bus_req_own),
    .req_addr (bus_req_addr),
    .req_kind (bus_req_kind),
    .kill     (race_kill)
  );

  assign alloc_ok = bus_req_valid && kind_tracked(bus_req_kind) && !race_kill;

  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_slot
    assign alloc_hit[i] = alloc_ok && (bus_req_tag == TAG_W'(i));
    assign free_hit[i]  = bus_rsp_valid && (bus_rsp_tag == TAG_W'(i));
    assign snp_hit[i]   = snp_valid && (snp_tag == TAG_W'(i));
    assign grab_hit[i]  = cpu_req_valid && (look_dec == DEC_JOIN) && join_sel[i];

    // The lookup sees the table after this cycle's write and release.
    assign vis_valid[i] = alloc_hit[i] || (e_valid[i] && !free_hit[i]);
    assign vis_addr[i]  = alloc_hit[i] ? bus_req_addr : e_addr[i];
    assign vis_kind[i]  = alloc_hit[i] ? bus_req_kind : e_kind[i];

    ort_entry #(.ADDR_W(ADDR_W), .STATE_W(STATE_W)) u_entry (
      .clk       (clk),
      .rst       (rst),
      .alloc_en  (alloc_hit[i]),
      .alloc_addr(bus_req_addr),
      .alloc_kind(bus_req_kind),
      .alloc_orig(bus_req_own),
      .free_en   (free_hit[i]),
      .snp_en    (snp_hit[i]),
      .snp_state (snp_state),
      .grab_en   (grab_hit[i]),
      .ent_valid (e_valid[i]),
      .ent_addr  (e_addr[i]),
      .ent_kind  (e_kind[i]),
      .ent_orig  (e_orig[i]),
      .ent_grab  (e_grab[i]),
      .ent_state (e_state[i])
    );
  end

  ort_match #(.N(NUM_TAGS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_match (
    .vis_valid(vis_valid),
    .vis_addr (vis_addr),
    .vis_kind (vis_kind),
    .look_addr(cpu_req_addr),
    .look_kind(cpu_req_kind),
    .dec      (look_dec),
    .dec_tag  (look_tag),
    .join_sel (join_sel)
  );

  logic rel_valid;
  assign rel_valid = bus_rsp_valid && e_valid[bus_rsp_tag];

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_dec_valid  <= 1'b0;
      cpu_dec        <= DEC_ISSUE;
      cpu_dec_tag    <= '0;
      rsp_out_valid  <= 1'b0;
      rsp_out_tag    <= '0;
      rsp_out_orig   <= 1'b0;
      rsp_out_grab   <= 1'b0;
      rsp_out_state  <= '0;
      shared_out     <= 1'b0;
      withdraw_valid <= 1'b0;
      withdraw_tag   <= '0;
    end else begin
      cpu_dec_valid  <= cpu_req_valid;
      cpu_dec        <= cpu_req_valid ? look_dec : DEC_ISSUE;
      cpu_dec_tag    <= cpu_req_valid ? look_tag : '0;
      rsp_out_valid  <= rel_valid;
      rsp_out_tag    <= rel_valid ? bus_rsp_tag : '0;
      rsp_out_orig   <= rel_valid && e_orig[bus_rsp_tag];
      rsp_out_grab   <= rel_valid && e_grab[bus_rsp_tag];
      rsp_out_state  <= rel_valid ? e_state[bus_rsp_tag] : '0;
      shared_out     <= rel_valid && e_grab[bus_rsp_tag];
      withdraw_valid <= race_kill;
      withdraw_tag   <= race_kill ? bus_req_tag : '0;
    end
  end
endmodule

// File: rtl/ort_checker.sv
module ort_checker #(
  parameter int TAG_W   = 3,
  parameter int STATE_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req_valid,
  input logic             bus_req_own,
  input logic             bus_rsp_valid,
  input logic             cpu_req_valid,
  input logic             cpu_dec_valid,
  input logic [1:0]       cpu_dec,
  input logic             rsp_out_valid,
  input logic             rsp_out_grab,
  input logic             shared_out,
  input logic             withdraw_valid
);
  assert_dec_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_req_valid |=> cpu_dec_valid);

  assert_dec_only_after_req_R11: assert property (@(posedge clk) disable iff (rst)
    !cpu_req_valid |=> !cpu_dec_valid);

  assert_dec_code_legal_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_dec_valid |-> (cpu_dec != 2'd3));

  assert_release_needs_rsp_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_out_valid |-> $past(bus_rsp_valid));

  assert_shared_only_on_grab_R3: assert property (@(posedge clk) disable iff (rst)
    shared_out |-> (rsp_out_valid && rsp_out_grab));

  assert_withdraw_needs_own_R8: assert property (@(posedge clk) disable iff (rst)
    withdraw_valid |-> $past(bus_req_valid && bus_req_own));
endmodule

bind outstanding_req_table ort_checker #(.TAG_W(TAG_W), .STATE_W(STATE_W)) u_ort_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_req_valid (bus_req_valid),
  .bus_req_own   (bus_req_own),
  .bus_rsp_valid (bus_rsp_valid),
  .cpu_req_valid (cpu_req_valid),
  .cpu_dec_valid (cpu_dec_valid),
  .cpu_dec       (cpu_dec),
  .rsp_out_valid (rsp_out_valid),
  .rsp_out_grab  (rsp_out_grab),
  .shared_out    (shared_out),
  .withdraw_valid(withdraw_valid)
);

// File: tb/tb_outstanding_req_table.sv
module tb_outstanding_req_table;
  localparam int TAG_W   = 3;
  localparam int ADDR_W  = 26;
  localparam int STATE_W = 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bus_req_valid = 1'b0, bus_req_own = 1'b0;
  logic [TAG_W-1:0]   bus_req_tag = '0;
  logic [ADDR_W-1:0]  bus_req_addr = '0;
  logic [1:0]         bus_req_kind = '0;
  logic               bus_rsp_valid = 1'b0;
  logic [TAG_W-1:0]   bus_rsp_tag = '0;
  logic               snp_valid = 1'b0;
  logic [TAG_W-1:0]   snp_tag = '0;
  logic [STATE_W-1:0] snp_state = '0;
  logic               cpu_req_valid = 1'b0;
  logic [ADDR_W-1:0]  cpu_req_addr = '0;
  logic [1:0]         cpu_req_kind = '0;
  logic               cpu_dec_valid;
  logic [1:0]         cpu_dec;
  logic [TAG_W-1:0]   cpu_dec_tag;
  logic               rsp_out_valid;
  logic [TAG_W-1:0]   rsp_out_tag;
  logic               rsp_out_orig, rsp_out_grab;
  logic [STATE_W-1:0] rsp_out_state;
  logic               shared_out;
  logic               withdraw_valid;
  logic [TAG_W-1:0]   withdraw_tag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  outstanding_req_table dut (
    .clk(clk), .rst(rst),
    .bus_req_valid(bus_req_valid), .bus_req_own(bus_req_own),
    .bus_req_tag(bus_req_tag), .bus_req_addr(bus_req_addr), .bus_req_kind(bus_req_kind),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_tag(bus_rsp_tag),
    .snp_valid(snp_valid), .snp_tag(snp_tag), .snp_state(snp_state),
    .cpu_req_valid(cpu_req_valid), .cpu_req_addr(cpu_req_addr), .cpu_req_kind(cpu_req_kind),
    .cpu_dec_valid(cpu_dec_valid), .cpu_dec(cpu_dec), .cpu_dec_tag(cpu_dec_tag),
    .rsp_out_valid(rsp_out_valid), .rsp_out_tag(rsp_out_tag),
    .rsp_out_orig(rsp_out_orig), .rsp_out_grab(rsp_out_grab),
    .rsp_out_state(rsp_out_state), .shared_out(shared_out),
    .withdraw_valid(withdraw_valid), .withdraw_tag(withdraw_tag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic clear_inputs();
    bus_req_valid = 1'b0; bus_req_own = 1'b0;
    bus_rsp_valid = 1'b0; snp_valid = 1'b0; cpu_req_valid = 1'b0;
  endtask

  // Inputs set before the call are captured at the next rising edge;
  // the registered outputs are read at the following falling edge.
  task automatic tick();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic put_bus(input int tag, input int addr, input int kind, input bit own);
    bus_req_valid = 1'b1; bus_req_own = own;
    bus_req_tag = TAG_W'(tag); bus_req_addr = ADDR_W'(addr); bus_req_kind = 2'(kind);
  endtask

  task automatic put_rsp(input int tag);
    bus_rsp_valid = 1'b1; bus_rsp_tag = TAG_W'(tag);
  endtask

  task automatic put_cpu(input int addr, input int kind);
    cpu_req_valid = 1'b1; cpu_req_addr = ADDR_W'(addr); cpu_req_kind = 2'(kind);
  endtask

  task automatic look(input string req, input int addr, input int kind,
                      input int exp_dec, input int exp_tag);
    put_cpu(addr, kind);
    tick();
    eq(req, "dec_valid", int'(cpu_dec_valid), 1);
    eq(req, "decision", int'(cpu_dec), exp_dec);
    if (exp_dec != 0) eq(req, "dec_tag", int'(cpu_dec_tag), exp_tag);
  endtask

  task automatic respond(input string req, input int tag, input int v, input int orig,
                         input int grab, input int state);
    put_rsp(tag);
    tick();
    eq(req, "rsp_valid", int'(rsp_out_valid), v);
    if (v != 0) begin
      eq(req, "rsp_tag", int'(rsp_out_tag), tag);
      eq(req, "rsp_orig", int'(rsp_out_orig), orig);
      eq(req, "rsp_grab", int'(rsp_out_grab), grab);
      eq(req, "rsp_state", int'(rsp_out_state), state);
    end
    eq(req, "shared", int'(shared_out), grab & v);
  endtask

  task automatic t_reset();
    eq("R1", "dec_valid at reset", int'(cpu_dec_valid), 0);
    eq("R1", "rsp_valid at reset", int'(rsp_out_valid), 0);
    eq("R1", "withdraw at reset", int'(withdraw_valid), 0);
    eq("R1", "shared at reset", int'(shared_out), 0);
    look("R1", 'h100, 0, 0, 0);
  endtask

  task automatic t_alloc_stall();
    put_bus(3, 'h2A0, 1, 1'b0);
    tick();
    look("R2", 'h2A0, 0, 1, 3);          // R4: read behind ownership read
    look("R4", 'h2A0, 1, 1, 3);
    look("R2", 'h2A1, 1, 0, 0);
  endtask

  task automatic t_free_state();
    snp_valid = 1'b1; snp_tag = 3'd3; snp_state = 2'd2;
    tick();
    respond("R6", 3, 1, 0, 0, 2);
    look("R5", 'h2A0, 0, 0, 0);
  endtask

  task automatic t_join();
    put_bus(5, 'h3C4, 0, 1'b1);
    tick();
    look("R3", 'h3C4, 0, 2, 5);
    look("R4", 'h3C4, 1, 1, 5);
    respond("R3", 5, 1, 1, 1, 0);
    look("R5", 'h3C4, 0, 0, 0);
  endtask

  task automatic t_untracked();
    put_bus(1, 'h055, 3, 1'b0);
    tick();
    put_bus(2, 'h055, 2, 1'b1);
    tick();
    look("R7", 'h055, 1, 0, 0);
    respond("R10", 1, 0, 0, 0, 0);
  endtask

  task automatic t_same_cycle();
    put_bus(6, 'h1F0, 1, 1'b0);
    put_cpu('h1F0, 0);
    tick();
    eq("R9", "same-cycle write decision", int'(cpu_dec), 1);
    eq("R9", "same-cycle write tag", int'(cpu_dec_tag), 6);
    put_rsp(6);
    put_cpu('h1F0, 0);
    tick();
    eq("R9", "same-cycle release decision", int'(cpu_dec), 0);
    eq("R9", "release report", int'(rsp_out_valid), 1);
  endtask

  task automatic t_race();
    put_bus(0, 'h0E0, 1, 1'b0);
    tick();
    eq("R8", "no withdraw for foreign", int'(withdraw_valid), 0);
    put_bus(4, 'h0E0, 0, 1'b1);
    tick();
    eq("R8", "withdraw pulse", int'(withdraw_valid), 1);
    eq("R8", "withdraw tag", int'(withdraw_tag), 4);
    tick();
    eq("R8", "withdraw one cycle", int'(withdraw_valid), 0);
    respond("R8", 4, 0, 0, 0, 0);
    look("R8", 'h0E0, 0, 1, 0);
    respond("R5", 0, 1, 0, 0, 0);
    put_bus(0, 'h0F0, 0, 1'b0);
    tick();
    put_bus(4, 'h0F0, 0, 1'b1);
    tick();
    eq("R8", "adjacent reads no withdraw", int'(withdraw_valid), 0);
    look("R8", 'h0F0, 0, 2, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_alloc_stall();
    t_free_state();
    t_join();
    t_untracked();
    t_same_cycle();
    t_race();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule